// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Victim Pointer

This block maps virtual addresses to physical addresses through a small, fully associative table of page mappings. A lookup request compares the address against every entry in parallel. The result is registered, so it appears one cycle after the request. A lookup that finds no entry does not start any hardware table walk. It raises a miss-trap output, and system software is expected to install the mapping.

Software installs a mapping through a write port that names the slot, the virtual page, the physical page, the page-size code and the valid bit. To choose the slot, software reads a victim pointer. The hardware keeps this pointer up to date with a pseudo-least-recently-used tree. Every hit and every software write counts as a use of that slot, and the pointer moves away from it. Each entry carries its own page size, from 8 KB up to 16 MB. The offset bits for that size pass through untranslated. A flush input drops every mapping at once.

Top module: `tlb_swrefill`

## Requirements
- R1: The response to a lookup request appears on the outputs in the cycle after the request, with `rsp_valid` high. In a cycle after one with no request, `rsp_valid`, `rsp_hit` and `rsp_miss_trap` are all low.
- R2: A valid response has exactly one of `rsp_hit` or `rsp_miss_trap` high. The miss trap is raised only when no valid entry matches, and a miss never changes the table contents.
- R3: The page-size code `c` selects an offset width of 13+c bits for codes 0 to 11, which covers 8 KB to 16 MB. Codes 12 to 15 behave as code 11. The virtual tag comparison ignores the address bits below the offset width.
- R4: On a hit, `rsp_paddr` takes the matching entry's physical page bits at and above the offset width and the lookup address bits below it. `rsp_slot` gives the matching entry's index.
- R5: When several entries match, the lowest index wins and `rsp_multi` is set. `rsp_multi` is low when one entry or none matches.
- R6: A write is used by lookups requested in the following cycle or later. A lookup requested in the same cycle as the write sees the old contents. A write with `wr_live` low removes the mapping in that slot.
- R7: `flush_all` clears every valid bit. It takes priority over a write in the same cycle, so that write installs nothing.
- R8: After reset every entry is invalid, `lru_slot` is 0, and `rsp_valid`, `rsp_hit`, `rsp_miss_trap` and `rsp_multi` are low.
- R9: A cycle that writes slot `s`, or that has a lookup hitting slot `s` and no write, leaves `lru_slot` different from `s` in the next cycle. When a write and a hit fall in the same cycle, the write selects the slot that is marked used.
- R10: Starting from reset, a use of slot 0 moves `lru_slot` to ENTRIES/2. ENTRIES successive writes, each to the slot `lru_slot` shows at that moment, cover every slot exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Clear every valid bit |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| wr_en | input | 1 | Write one table slot |
| wr_slot | input | IDX_W | Slot to write |
| wr_live | input | 1 | Valid bit written into the slot |
| wr_vpage | input | VA_W-13 | Virtual page number (address bits 13 and up) |
| wr_ppage | input | PA_W-13 | Physical page number (address bits 13 and up) |
| wr_size | input | SZ_W | Page-size code |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss_trap | output | 1 | No entry matched; software refill needed |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_slot | output | IDX_W | Index of the winning entry |
| rsp_paddr | output | PA_W | Translated physical address |
| lru_slot | output | IDX_W | Slot that software should overwrite next |

## Verification
The bench builds the table with 16 entries, a 32-bit virtual and physical address, and twelve page sizes. The small table lets the bench overwrite every slot through the victim pointer within a few cycles, which exercises the full pointer rotation. It also makes multi-hit overlaps, clamped size codes, and the interplay of flush with write and of write with lookup cheap to reach. A behavioural model predicts every response. On every cycle that marks a slot as used, the bench checks that `lru_slot` has moved away from that slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Offset width in bits for a page-size code; codes past the last size clamp.
  function automatic int page_shift(input int code, input int min_shift,
                                    input int nsizes);
    if (code >= nsizes) return min_shift + nsizes - 1;
    return min_shift + code;
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int VPN_W = 19,
  parameter int PPN_W = 19,
  parameter int SZ_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic             wr_live,
  input  logic [VPN_W-1:0] wr_vpage,
  input  logic [PPN_W-1:0] wr_ppage,
  input  logic [SZ_W-1:0]  wr_size,
  output logic [N-1:0]     ent_valid,
  output logic [VPN_W-1:0] ent_vpage [N],
  output logic [PPN_W-1:0] ent_ppage [N],
  output logic [SZ_W-1:0]  ent_size  [N]
);

  logic do_write;
  assign do_write = wr_en && !flush_all;

  // Valid bits need reset and flush; kept apart from the payload.
  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      ent_valid <= '0;
    end else if (wr_en) begin
      ent_valid[wr_slot] <= wr_live;
    end
  end

  // Payload fields: single write port, no reset.
  always_ff @(posedge clk) begin
    if (do_write) begin
      ent_vpage[wr_slot] <= wr_vpage;
      ent_ppage[wr_slot] <= wr_ppage;
      ent_size[wr_slot]  <= wr_size;
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N         = 64,
  parameter int VPN_W     = 19,
  parameter int SZ_W      = 4,
  parameter int MIN_SHIFT = 13,
  parameter int NSIZES    = 12
) (
  input  logic [VPN_W-1:0] va_page,
  input  logic [N-1:0]     ent_valid,
  input  logic [VPN_W-1:0] ent_vpage [N],
  input  logic [SZ_W-1:0]  ent_size  [N],
  output logic [N-1:0]     match
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [VPN_W-1:0] keep;
    logic [VPN_W-1:0] diff;
    int               drop;

    always_comb begin
      drop = page_shift(int'(ent_size[g]), MIN_SHIFT, NSIZES) - MIN_SHIFT;
      for (int i = 0; i < VPN_W; i++) begin
        keep[i] = (i >= drop);
      end
    end

    assign diff     = (va_page ^ ent_vpage[g]) & keep;
    assign match[g] = ent_valid[g] && (diff == '0);
  end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     match,
  output logic [IDX_W-1:0] slot,
  output logic             any,
  output logic             multi
);

  always_comb begin
    slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) slot = IDX_W'(i);
    end
  end

  assign any   = |match;
  assign multi = ($countones(match) > 1);

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_slot,
  output logic [IDX_W-1:0] victim
);

  // Heap-ordered tree: node n (1..N-1) lives in bit n-1; a 1 points right.
  logic [N-2:0] tree, tree_nxt;

  always_comb begin
    int node;
    tree_nxt = tree;
    node     = 1;
    if (touch_en) begin
      for (int l = 0; l < IDX_W; l++) begin
        tree_nxt[node-1] = !touch_slot[IDX_W-1-l];
        node = 2 * node + int'(touch_slot[IDX_W-1-l]);
      end
    end
  end

  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < IDX_W; l++) begin
      node = 2 * node + int'(tree[node-1]);
    end
    victim = IDX_W'(node - N);
  end

  always_ff @(posedge clk) begin
    if (rst) tree <= '0;
    else     tree <= tree_nxt;
  end

endmodule

// File: rtl/tlb_swrefill.sv
module tlb_swrefill
  import tlb_pkg::*;
#(
  parameter  int ENTRIES   = 64,
  parameter  int VA_W      = 32,
  parameter  int PA_W      = 32,
  parameter  int MIN_SHIFT = 13,
  parameter  int NSIZES    = 12,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VPN_W     = VA_W - MIN_SHIFT,
  localparam int PPN_W     = PA_W - MIN_SHIFT,
  localparam int SZ_W      = $clog2(NSIZES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_all,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic             wr_live,
  input  logic [VPN_W-1:0] wr_vpage,
  input  logic [PPN_W-1:0] wr_ppage,
  input  logic [SZ_W-1:0]  wr_size,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss_trap,
  output logic             rsp_multi,
  output logic [IDX_W-1:0] rsp_slot,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [IDX_W-1:0] lru_slot
);

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpage [ENTRIES];
  logic [PPN_W-1:0]   ent_ppage [ENTRIES];
  logic [SZ_W-1:0]    ent_size  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   pick_slot;
  logic               pick_any, pick_multi;

  tlb_store #(
    .N(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .SZ_W(SZ_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush_all(flush_all),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_live(wr_live),
    .wr_vpage(wr_vpage), .wr_ppage(wr_ppage), .wr_size(wr_size),
    .ent_valid(ent_valid), .ent_vpage(ent_vpage),
    .ent_ppage(ent_ppage), .ent_size(ent_size)
  );

  tlb_match #(
    .N(ENTRIES), .VPN_W(VPN_W), .SZ_W(SZ_W),
    .MIN_SHIFT(MIN_SHIFT), .NSIZES(NSIZES)
  ) u_match (
    .va_page(lk_vaddr[VA_W-1:MIN_SHIFT]),
    .ent_valid(ent_valid), .ent_vpage(ent_vpage), .ent_size(ent_size),
    .match(match)
  );

  tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .match(match), .slot(pick_slot), .any(pick_any), .multi(pick_multi)
  );

  // Use tracking: a write names its slot, otherwise a hitting lookup does.
  logic             touch_en;
  logic [IDX_W-1:0] touch_slot;
  assign touch_en   = wr_en || (lk_req && pick_any);
  assign touch_slot = wr_en ? wr_slot : pick_slot;

  tlb_plru #(.N(ENTRIES), .IDX_W(IDX_W)) u_plru (
    .clk(clk), .rst(rst), .touch_en(touch_en),
    .touch_slot(touch_slot), .victim(lru_slot)
  );

  // Address assembly for the winning entry.
  logic [PA_W-1:0] low_mask, page_base, paddr_c;
  int              sel_shift;

  always_comb begin
    sel_shift = page_shift(int'(ent_size[pick_slot]), MIN_SHIFT, NSIZES);
    for (int j = 0; j < PA_W; j++) begin
      low_mask[j] = (j < sel_shift);
    end
  end

  assign page_base = {ent_ppage[pick_slot], {MIN_SHIFT{1'b0}}};
  assign paddr_c   = (page_base & ~low_mask) | (PA_W'(lk_vaddr) & low_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_miss_trap <= 1'b0;
      rsp_multi     <= 1'b0;
      rsp_slot      <= '0;
      rsp_paddr     <= '0;
    end else begin
      rsp_valid     <= lk_req;
      rsp_hit       <= lk_req && pick_any;
      rsp_miss_trap <= lk_req && !pick_any;
      rsp_multi     <= lk_req && pick_multi;
      rsp_slot      <= pick_slot;
      rsp_paddr     <= pick_any ? paddr_c : '0;
    end
  end

endmodule

// File: rtl/tlb_swrefill_chk.sv
module tlb_swrefill_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             flush_all,
  input logic             lk_req,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_slot,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss_trap,
  input logic             rsp_multi,
  input logic [IDX_W-1:0] rsp_slot,
  input logic [IDX_W-1:0] lru_slot
);

  // R1: a request yields a response one cycle later
  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R1: no request, quiet response
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_miss_trap));

  // R2: hit and miss trap are exclusive and complete
  a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss_trap));

  // R5: multiple match is a kind of hit
  a_r5_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

  // R7: lookup right after a flush misses
  a_r7_flush_then_miss: assert property (@(posedge clk) disable iff (rst)
    (flush_all ##1 lk_req) |=> rsp_miss_trap);

  // R9: written slot is not the next victim
  a_r9_write_moves_victim: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (lru_slot != $past(wr_slot)));

  // R9: hit slot is not the next victim
  a_r9_hit_moves_victim: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !wr_en) |=> (!rsp_hit || (lru_slot != rsp_slot)));

endmodule

bind tlb_swrefill tlb_swrefill_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .flush_all(flush_all), .lk_req(lk_req),
  .wr_en(wr_en), .wr_slot(wr_slot), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss_trap(rsp_miss_trap), .rsp_multi(rsp_multi),
  .rsp_slot(rsp_slot), .lru_slot(lru_slot)
);

// File: tb/test_tlb_swrefill.sv
module test_tlb_swrefill;

  localparam int NENT = 16;
  localparam int IW   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush_all = 1'b0;
  logic          lk_req = 1'b0;
  logic [31:0]   lk_vaddr = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_slot = '0;
  logic          wr_live = 1'b0;
  logic [18:0]   wr_vpage = '0;
  logic [18:0]   wr_ppage = '0;
  logic [3:0]    wr_size = '0;
  logic          rsp_valid, rsp_hit, rsp_miss_trap, rsp_multi;
  logic [IW-1:0] rsp_slot, lru_slot;
  logic [31:0]   rsp_paddr;

  always #5 clk = ~clk;

  tlb_swrefill #(.ENTRIES(NENT)) i_tlb_swrefill (
    .clk(clk), .rst(rst), .flush_all(flush_all), .lk_req(lk_req),
    .lk_vaddr(lk_vaddr), .wr_en(wr_en), .wr_slot(wr_slot), .wr_live(wr_live),
    .wr_vpage(wr_vpage), .wr_ppage(wr_ppage), .wr_size(wr_size),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss_trap(rsp_miss_trap),
    .rsp_multi(rsp_multi), .rsp_slot(rsp_slot), .rsp_paddr(rsp_paddr),
    .lru_slot(lru_slot)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference table
  bit          mval [NENT];
  int unsigned mvp  [NENT];
  int unsigned mpp  [NENT];
  int unsigned msz  [NENT];

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_look(input int unsigned va, output bit hit,
                                     output bit multi, output int slot,
                                     output longint pa);
    hit = 0; multi = 0; slot = 0; pa = 0;
    for (int i = 0; i < NENT; i++) begin
      int sh;
      longint lowm;
      sh   = (msz[i] >= 12) ? 24 : 13 + int'(msz[i]);
      lowm = (longint'(1) << sh) - 1;
      if (mval[i] && ((((va >> 13) ^ mvp[i]) >> (sh - 13)) == 0)) begin
        if (!hit) begin
          hit  = 1;
          slot = i;
          pa   = ((longint'(mpp[i]) << 13) & ~lowm & 64'hFFFF_FFFF) |
                 (longint'(va) & lowm);
        end else begin
          multi = 1;
        end
      end
    end
  endfunction

  // One clock: predict, advance, update model, compare at the falling edge.
  task automatic step();
    bit e_hit, e_multi, e_req;
    int e_slot, touched;
    longint e_pa;
    e_req = lk_req;
    model_look(lk_vaddr, e_hit, e_multi, e_slot, e_pa);
    touched = wr_en ? int'(wr_slot) : ((lk_req && e_hit) ? e_slot : -1);
    @(posedge clk);
    if (flush_all) begin
      for (int i = 0; i < NENT; i++) mval[i] = 0;
    end else if (wr_en) begin
      mval[wr_slot] = wr_live;
      mvp[wr_slot]  = wr_vpage;
      mpp[wr_slot]  = wr_ppage;
      msz[wr_slot]  = wr_size;
    end
    @(negedge clk);
    chk(rsp_valid == e_req, "R1 valid", rsp_valid, e_req);
    chk(rsp_hit == (e_req && e_hit), "R2 hit", rsp_hit, e_req && e_hit);
    chk(rsp_miss_trap == (e_req && !e_hit), "R2 miss", rsp_miss_trap,
        e_req && !e_hit);
    chk(rsp_multi == (e_req && e_multi), "R5 multi", rsp_multi,
        e_req && e_multi);
    if (e_req && e_hit) begin
      chk(int'(rsp_slot) == e_slot, "R4 slot", rsp_slot, e_slot);
      chk(longint'(rsp_paddr) == e_pa, "R4 paddr", rsp_paddr, e_pa);
    end
    if (touched >= 0)
      chk(int'(lru_slot) != touched, "R9 victim moved", lru_slot, touched);
  endtask

  task automatic set_write(input int slot, input bit live, input int unsigned va,
                           input int unsigned pa, input int sz);
    wr_en    = 1'b1;
    wr_slot  = IW'(slot);
    wr_live  = live;
    wr_vpage = 19'(va >> 13);
    wr_ppage = 19'(pa >> 13);
    wr_size  = 4'(sz);
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; lk_req = 1'b0; flush_all = 1'b0;
  endtask

  task automatic do_write(input int slot, input bit live, input int unsigned va,
                          input int unsigned pa, input int sz);
    set_write(slot, live, va, pa, sz);
    step();
    idle_inputs();
  endtask

  task automatic do_look(input int unsigned va);
    lk_req   = 1'b1;
    lk_vaddr = va;
    step();
    idle_inputs();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen [NENT];
    int unsigned r;
    for (int i = 0; i < NENT; i++) begin
      mval[i] = 0; mvp[i] = 0; mpp[i] = 0; msz[i] = 0; seen[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk(!rsp_valid && !rsp_hit && !rsp_miss_trap && !rsp_multi, "R8 outputs",
        {rsp_valid, rsp_hit, rsp_miss_trap, rsp_multi}, 0);
    chk(lru_slot == 0, "R8 victim", lru_slot, 0);

    // R2 empty table misses; R8 nothing valid
    do_look(32'h1234_5678);
    chk(rsp_miss_trap == 1'b1, "R2 empty miss", rsp_miss_trap, 1);

    // R10 first use of slot 0 sends the victim to the middle
    do_write(0, 1, 32'h0040_0000, 32'h8000_0000, 0);
    chk(int'(lru_slot) == NENT / 2, "R10 first use", lru_slot, NENT / 2);

    // R4 8 KB page
    do_look(32'h0040_0123);
    chk(rsp_paddr == 32'h8000_0123, "R4 8KB paddr", rsp_paddr, 32'h8000_0123);
    do_look(32'h0040_2000);
    chk(rsp_miss_trap == 1'b1, "R3 next 8KB page misses", rsp_miss_trap, 1);

    // R3 16 MB page, low physical bits ignored
    do_write(1, 1, 32'h0300_0000, 32'h51AB_C000, 11);
    do_look(32'h03AB_CDEF);
    chk(rsp_paddr == 32'h51AB_CDEF, "R3 16MB paddr", rsp_paddr, 32'h51AB_CDEF);

    // R3 clamped code behaves as 16 MB
    do_write(2, 1, 32'h0500_0000, 32'h6000_0000, 14);
    do_look(32'h05FF_FFFF);
    chk(rsp_hit == 1'b1, "R3 clamp hit", rsp_hit, 1);
    do_look(32'h0600_0000);
    chk(rsp_miss_trap == 1'b1, "R3 clamp edge", rsp_miss_trap, 1);

    // R5 overlapping 128 KB page in slot 5
    do_write(5, 1, 32'h0040_0000, 32'h9000_0000, 4);
    do_look(32'h0040_0123);
    chk(rsp_multi && rsp_slot == 0, "R5 lowest wins", rsp_slot, 0);
    do_look(32'h0041_0000);
    chk(!rsp_multi && rsp_slot == 5, "R5 single match", rsp_slot, 5);

    // R6 write and lookup in the same cycle: old contents
    set_write(3, 1, 32'h0700_0000, 32'hA000_0000, 0);
    lk_req = 1'b1; lk_vaddr = 32'h0700_0010;
    step();
    idle_inputs();
    chk(rsp_miss_trap == 1'b1, "R6 same cycle old", rsp_miss_trap, 1);
    do_look(32'h0700_0010);
    chk(rsp_hit == 1'b1, "R6 next cycle new", rsp_hit, 1);
    do_write(3, 0, 32'h0700_0000, 32'hA000_0000, 0);
    do_look(32'h0700_0010);
    chk(rsp_miss_trap == 1'b1, "R6 live low removes", rsp_miss_trap, 1);

    // R7 flush beats a same-cycle write
    flush_all = 1'b1;
    set_write(4, 1, 32'h0900_0000, 32'hB000_0000, 0);
    step();
    idle_inputs();
    do_look(32'h0900_0000);
    chk(rsp_miss_trap == 1'b1, "R7 write dropped", rsp_miss_trap, 1);
    do_look(32'h0300_0000);
    chk(rsp_miss_trap == 1'b1, "R7 old entry gone", rsp_miss_trap, 1);

    // R10 refill every slot through the victim pointer
    for (int n = 0; n < NENT; n++) begin
      int s;
      s = int'(lru_slot);
      chk(!seen[s], "R10 victim repeats", s, n);
      seen[s] = 1;
      do_write(s, 1, 32'h1000_0000 + n * 32'h2000, 32'h2000_0000 + n * 32'h4000,
               n % 3);
    end

    // Mixed traffic against the model
    r = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      if (r[27:24] == 4'hF) begin
        set_write(int'(r[3:0]), 1, 32'h1000_0000 + (r[12:8] % 20) * 32'h2000,
                  {r[31:13], 13'h0}, int'(r[20:19]));
      end
      lk_req   = 1'b1;
      lk_vaddr = 32'h1000_0000 + (r[12:8] % 20) * 32'h2000 + {19'h0, r[23:11]};
      step();
      idle_inputs();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule